// File: doc/BRIEF.md
# Three-Stage Gain Split Decoder

This block turns one requested gain, given in half-decibel units, into control words for three cascaded amplifier stages. The front stage offers 0, 10 or 20 dB as a one-hot field. The middle stage covers 0 to 10 dB in 0.5 dB steps. The back stage offers 0 or 10 dB. The request comes from a 7-bit parallel pin bus or from a register value. The register source can also skip the decoder and drive the three stage fields directly from a 9-bit raw word.

A settle filter sits between the selected word and the registered outputs. The filter passes a new word only after it has held steady for a programmable number of system clocks. Stray codes that appear while the parallel bits switch at slightly different times therefore never reach the stages. All three fields update together in a single cycle. A runtime control turns the filter off, and the outputs then follow the selection one clock later.

Top module: `gain_split_decoder`

## Requirements
- R1: While reset is high, the outputs go on the next clock edge to front field 3'b001 (0 dB), middle field 0 and back stage off. They stay there until new input passes the filter.
- R2: In decoded mode the front one-hot field uses bit 0 for 0 dB, bit 1 for 10 dB and bit 2 for 20 dB. Codes 0 to 19 select bit 0, codes 20 to 39 select bit 1, and codes of 40 and above select bit 2.
- R3: In decoded mode the back stage turns on only for codes above 60, that is, only once the front stage holds 20 dB and more than 20 half-steps remain.
- R4: In decoded mode the middle field (0 to 20 half-steps) equals the code minus 20 for each 10 dB step taken by the front and back stages. The three stages therefore always add up to the requested code.
- R5: Codes above 80 give the same outputs as code 80: front 3'b100, middle 20, back on.
- R6: When `use_reg` is 0 the gain comes from `pin_code`. Changes to `reg_word` have no effect on the outputs.
- R7: When `use_reg` is 1 and `raw_mode` is 0, the decoder uses `reg_word[6:0]` and ignores `reg_word[8:7]`.
- R8: When `use_reg` is 1 and `raw_mode` is 1, the outputs copy `reg_word` directly: bit 8 goes to the back stage, bits [7:5] to the front field and bits [4:0] to the middle field.
- R9: The pin source is always decoded. Setting `raw_mode` while `use_reg` is 0 does not change the outputs.
- R10: With `filt_off` at 0, a new selected word reaches the outputs on the (S+1)th clock edge after it appears. S is `settle_cycles`, and a value of 0 counts as 1. All fields change on that same edge.
- R11: With the filter on, a word held for fewer than S clocks never reaches the outputs.
- R12: With `filt_off` at 1, the outputs take the selected word on the first clock edge after it appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_code | input | 7 | Parallel gain request, half-dB units |
| reg_word | input | 9 | Register gain value: a code in [6:0], or a raw stage word |
| use_reg | input | 1 | 1 selects the register source, 0 selects the pins |
| raw_mode | input | 1 | With the register source, bypass the decoder |
| filt_off | input | 1 | 1 disables the settle filter |
| settle_cycles | input | 8 | Number of stable clocks the filter requires |
| front_oh | output | 3 | Front stage one-hot select (0/10/20 dB) |
| mid_half | output | 5 | Middle stage setting in half-dB steps |
| back_on | output | 1 | Back stage 10 dB enable |

## Verification
The hardest case to reach from the ports is the pin bus stepping through stray codes while its bits switch. Each stray code lasts less than the settle window, yet the final code must still appear on exactly the (S+1)th edge. The stimulus walks the pins from 30 to 75 through two short-lived intermediate codes, one cycle each. It then checks that the outputs still hold the old word after S edges and show the new word one edge later. A separate two-cycle excursion to another code, followed by a return, confirms that a brief change is filtered out completely.

// File: rtl/gsd_pkg.sv
`timescale 1ns/1ps
package gsd_pkg;

    localparam int CODE_W  = 7;
    localparam int MID_W   = 5;
    localparam int FRONT_W = 3;
    localparam int RAW_W   = 1 + FRONT_W + MID_W;
    localparam int STEP_10DB = 20;
    localparam int CODE_TOP  = 80;

    localparam logic [CODE_W-1:0] TOP_V  = CODE_W'(CODE_TOP);
    localparam logic [CODE_W-1:0] TIER_V = CODE_W'(STEP_10DB);
    localparam logic [CODE_W-1:0] TIER2_V = CODE_W'(2 * STEP_10DB);

    typedef struct packed {
        logic               back_on;
        logic [FRONT_W-1:0] front_oh;
        logic [MID_W-1:0]   mid_half;
    } stage_word_t;

    localparam stage_word_t IDLE_WORD = '{back_on: 1'b0, front_oh: 3'b001, mid_half: '0};

    typedef enum logic [1:0] {
        SRC_PIN     = 2'd0,
        SRC_REG_DEC = 2'd1,
        SRC_REG_RAW = 2'd2
    } src_mode_t;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
        return (c > TOP_V) ? TOP_V : c;
    endfunction

endpackage

// File: rtl/gsd_decode.sv
`timescale 1ns/1ps
module gsd_decode
    import gsd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output stage_word_t       word
);
    logic [CODE_W-1:0] rest;

    always_comb begin
        rest          = clamp_code(code);
        word.back_on  = 1'b0;
        word.front_oh = 3'b001;
        if (rest >= TIER2_V) begin
            word.front_oh = 3'b100;
            rest          = rest - TIER2_V;
            if (rest > TIER_V) begin
                word.back_on = 1'b1;
                rest         = rest - TIER_V;
            end
        end else if (rest >= TIER_V) begin
            word.front_oh = 3'b010;
            rest          = rest - TIER_V;
        end
        word.mid_half = rest[MID_W-1:0];
    end
endmodule

// File: rtl/gsd_source_mux.sv
`timescale 1ns/1ps
module gsd_source_mux
    import gsd_pkg::*;
(
    input  logic              use_reg,
    input  logic              raw_mode,
    input  logic [CODE_W-1:0] pin_code,
    input  logic [RAW_W-1:0]  reg_word,
    output stage_word_t       cand
);
    localparam int LANES = 2;

    logic [CODE_W-1:0] lane_code [LANES];
    stage_word_t       lane_word [LANES];
    src_mode_t         mode;

    assign lane_code[0] = pin_code;
    assign lane_code[1] = reg_word[CODE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        gsd_decode u_dec (
            .code (lane_code[g]),
            .word (lane_word[g])
        );
    end

    always_comb begin
        if (!use_reg)      mode = SRC_PIN;
        else if (raw_mode) mode = SRC_REG_RAW;
        else               mode = SRC_REG_DEC;
    end

    always_comb begin
        unique case (mode)
            SRC_PIN:     cand = lane_word[0];
            SRC_REG_DEC: cand = lane_word[1];
            SRC_REG_RAW: cand = stage_word_t'(reg_word);
            default:     cand = IDLE_WORD;
        endcase
    end
endmodule

// File: rtl/gsd_deglitch.sv
`timescale 1ns/1ps
module gsd_deglitch
    import gsd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter bit FILTER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             filt_off,
    input  logic [CNT_W-1:0] settle,
    input  stage_word_t      cand,
    output stage_word_t      held
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    if (FILTER_EN) begin : g_filter
        stage_word_t      seen_q;
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] need;
        logic             same;

        assign need = (settle == '0) ? CNT_W'(1) : settle;
        assign same = (cand == seen_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q <= IDLE_WORD;
                cnt_q  <= '0;
                held   <= IDLE_WORD;
            end else begin
                if (!same) begin
                    seen_q <= cand;
                    cnt_q  <= CNT_W'(1);
                end else if (cnt_q != CNT_SAT) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (filt_off)
                    held <= cand;
                else if (same && cnt_q >= need)
                    held <= seen_q;
            end
        end
    end else begin : g_direct
        always_ff @(posedge clk) begin
            if (rst) held <= IDLE_WORD;
            else     held <= cand;
        end
    end
endmodule

// File: rtl/gain_split_decoder.sv
`timescale 1ns/1ps
module gain_split_decoder
    import gsd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter bit FILTER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       pin_code,
    input  logic [8:0]       reg_word,
    input  logic             use_reg,
    input  logic             raw_mode,
    input  logic             filt_off,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic [2:0]       front_oh,
    output logic [4:0]       mid_half,
    output logic             back_on
);
    stage_word_t cand_word;
    stage_word_t out_word;

    gsd_source_mux u_mux (
        .use_reg  (use_reg),
        .raw_mode (raw_mode),
        .pin_code (pin_code),
        .reg_word (reg_word),
        .cand     (cand_word)
    );

    gsd_deglitch #(
        .CNT_W     (CNT_W),
        .FILTER_EN (FILTER_EN)
    ) u_filt (
        .clk      (clk),
        .rst      (rst),
        .filt_off (filt_off),
        .settle   (settle_cycles),
        .cand     (cand_word),
        .held     (out_word)
    );

    assign front_oh = out_word.front_oh;
    assign mid_half = out_word.mid_half;
    assign back_on  = out_word.back_on;
endmodule

// File: rtl/gain_split_decoder_chk.sv
`timescale 1ns/1ps
module gain_split_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] pin_code,
    input logic       use_reg,
    input logic       filt_off,
    input logic [8:0] cand_bits,
    input logic [2:0] front_oh,
    input logic [4:0] mid_half,
    input logic       back_on
);
    logic [8:0] out_bits;
    assign out_bits = {back_on, front_oh, mid_half};

    // R1: reset drives the idle word
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (front_oh == 3'b001 && mid_half == 5'd0 && !back_on));

    // R2: decoded pin source gives a one-hot front field
    a_r2_front_onehot: assert property (@(posedge clk) disable iff (rst)
        (filt_off && !use_reg) |=> $onehot(front_oh));

    // R3: back stage only on top of a 20 dB front stage
    a_r3_back_needs_front: assert property (@(posedge clk) disable iff (rst)
        (filt_off && !use_reg) |=> (!back_on || front_oh == 3'b100));

    // R5: oversized pin codes clamp to full gain
    a_r5_clamp_top: assert property (@(posedge clk) disable iff (rst)
        (filt_off && !use_reg && pin_code > 7'd80) |=>
        (front_oh == 3'b100 && mid_half == 5'd20 && back_on));

    // R11: a freshly changed word cannot reach the outputs on its first edge
    a_r11_no_early_pass: assert property (@(posedge clk) disable iff (rst)
        (!filt_off && cand_bits != $past(cand_bits)) |=> $stable(out_bits));

    // R12: with the filter off, outputs follow the selection after one edge
    a_r12_direct_follow: assert property (@(posedge clk) disable iff (rst)
        filt_off |=> (out_bits == $past(cand_bits)));
endmodule

bind gain_split_decoder gain_split_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_code  (pin_code),
    .use_reg   (use_reg),
    .filt_off  (filt_off),
    .cand_bits (cand_word),
    .front_oh  (front_oh),
    .mid_half  (mid_half),
    .back_on   (back_on)
);

// File: tb/gain_split_decoder_test.sv
`timescale 1ns/1ps
module gain_split_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] pin_code = '0;
    logic [8:0] reg_word = '0;
    logic       use_reg = 1'b0;
    logic       raw_mode = 1'b0;
    logic       filt_off = 1'b0;
    logic [7:0] settle_cycles = 8'd3;
    logic [2:0] front_oh;
    logic [4:0] mid_half;
    logic       back_on;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    gain_split_decoder uut (
        .clk           (clk),
        .rst           (rst),
        .pin_code      (pin_code),
        .reg_word      (reg_word),
        .use_reg       (use_reg),
        .raw_mode      (raw_mode),
        .filt_off      (filt_off),
        .settle_cycles (settle_cycles),
        .front_oh      (front_oh),
        .mid_half      (mid_half),
        .back_on       (back_on)
    );

    // expected stage word from the requirement text: {back, front one-hot, middle}
    function automatic logic [8:0] model(input int c);
        int f; int b; int m; logic [2:0] oh;
        if (c > 80) c = 80;
        if (c >= 40)      begin f = 40; oh = 3'b100; end
        else if (c >= 20) begin f = 20; oh = 3'b010; end
        else              begin f = 0;  oh = 3'b001; end
        b = (c > 60) ? 1 : 0;
        m = c - f - 20 * b;
        return {b[0], oh, m[4:0]};
    endfunction

    task automatic expect_after(input int edges, input logic [8:0] exp, input string tag);
        repeat (edges) @(posedge clk);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
    endtask

    // monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [8:0] act;
                it  = sb_q.pop_front();
                act = {back_on, front_oh, mid_half};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        expect_after(3, 9'b0_001_00000, "R1 reset idle word");
        rst = 1'b0;
        expect_after(6, 9'b0_001_00000, "R1 idle after reset");

        filt_off = 1'b1;
        pin_code = 7'd19; expect_after(1, model(19), "R2 code 19 front 0dB");
        pin_code = 7'd20; expect_after(1, model(20), "R2 code 20 front 10dB");
        pin_code = 7'd39; expect_after(1, model(39), "R2 code 39");
        pin_code = 7'd40; expect_after(1, model(40), "R2 code 40 front 20dB");
        pin_code = 7'd60; expect_after(1, model(60), "R3 code 60 back off");
        pin_code = 7'd61; expect_after(1, 9'b1_100_00001, "R3 code 61 back on");
        pin_code = 7'd53; expect_after(1, 9'b0_100_01101, "R4 code 53 middle 13");
        pin_code = 7'd80; expect_after(1, 9'b1_100_10100, "R4 code 80 full");
        pin_code = 7'd81; expect_after(1, 9'b1_100_10100, "R5 code 81 clamps");
        pin_code = 7'd127; expect_after(1, 9'b1_100_10100, "R5 code 127 clamps");

        pin_code = 7'd45; expect_after(1, model(45), "R12 one edge latency");
        reg_word = 9'b1_010_10011; expect_after(2, model(45), "R6 reg bits ignored");
        raw_mode = 1'b1; expect_after(2, model(45), "R9 pins stay decoded");

        raw_mode = 1'b0; use_reg = 1'b1;
        reg_word = 9'b1_1_0011001; expect_after(1, model(25), "R7 reg decoded, top bits ignored");
        raw_mode = 1'b1; reg_word = 9'b1_010_10011;
        expect_after(1, 9'b1_010_10011, "R8 raw word direct");

        use_reg = 1'b0; raw_mode = 1'b0; pin_code = 7'd80;
        expect_after(2, model(80), "R12 back to pins");
        filt_off = 1'b0; settle_cycles = 8'd3;
        expect_after(2, model(80), "R10 filter enable keeps word");
        pin_code = 7'd30;
        expect_after(3, model(80), "R10 held before S+1 edges");
        expect_after(1, model(30), "R10 updated at S+1 edge");

        pin_code = 7'd70;
        expect_after(2, model(30), "R11 short excursion hidden");
        pin_code = 7'd30;
        expect_after(8, model(30), "R11 excursion never passed");

        pin_code = 7'd31; @(posedge clk); @(negedge clk);
        pin_code = 7'd11; @(posedge clk); @(negedge clk);
        pin_code = 7'd75;
        expect_after(3, model(30), "R11 skew codes hidden");
        expect_after(1, 9'b1_100_01111, "R10 final code after skew");

        settle_cycles = 8'd0; pin_code = 7'd5;
        expect_after(1, model(75), "R10 zero settle counts as one");
        expect_after(1, model(5), "R10 zero settle update");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule